// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a bank of external interrupt request lines and turns each into a latched, maskable interrupt. Each line is first brought into the controller clock domain. A per-line sense code then chooses what counts as a request: an active-low level, an active-high level, a rising edge, a falling edge, or either edge. A qualifying condition sets that line's detect bit. The detect bit ANDed with the line's enable bit drives that line's interrupt output.

Software reaches the controller over a plain 32-bit register bus with an address, a write strobe with write data, and a read strobe whose data comes back from a register. Enables are never written as a whole word. One address sets enable bits and another clears them, so two agents can change different lines without a read-modify-write race. Detections are acknowledged by writing ones to the shared detect register. A level monitor register shows the synchronised state of every line.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero and every interrupt output is low.
- R2: A write to offset 0x08 sets the enable bit of every line whose write-data bit is 1 and leaves the other enable bits unchanged.
- R3: A write to offset 0x04 clears the enable bit of every line whose write-data bit is 1. A read of 0x04, or of 0x08, returns the current enable mask with line n in bit n.
- R4: Offset 0x100 reads the detect bits, with line n in bit n. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a bit with no new detection and no clear keeps its value.
- R5: Each line n has a 32-bit configuration word at 0x180 + 4·n that reads back exactly as written. Only bits [5:0] form the sense code, and the upper bits do not affect detection.
- R6: Sense code 0x01 detects a low level and code 0x02 detects a high level. The detect bit is set on every cycle the level is active, so a clear written while the level persists has no lasting effect.
- R7: Sense code 0x04 detects a falling edge, 0x08 a rising edge and 0x0C either edge. Edges are found by comparing the synchronised level with its value one clock earlier.
- R8: Any other sense code, including 0, never sets the detect bit of that line.
- R9: A read of offset 0x104 returns the synchronised level of every line.
- R10: A read of offset 0x00 returns the detect bits ANDed with the enable mask. Interrupt output n equals detect bit n AND enable bit n, and a disabled line keeps its detect bit.
- R11: When a detection and a software clear of the same bit fall in the same cycle, the detection wins and the bit stays set.
- R12: A line change that is present at clock edge k sets the detect bit, and the interrupt output, at edge k+2. Read data is registered and is valid after the clock edge at which the read strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, sampled at the rising clock edge |
| bus_rdata | output | 32 | Registered read data |
| irq_line_in | input | N_LINES | Asynchronous external interrupt lines |
| irq_out | output | N_LINES | Per-line interrupt requests, detect AND enable |

## Verification
Input lines are driven at the falling clock edge. A change driven there is caught by the first synchroniser flop at the next rising edge. The detect bit and interrupt output change two rising edges after that, so the bench samples the interrupt output at the falling edges after the first, second and third rising edges and expects it only at the third. Register writes and the read strobe are held across exactly one rising edge, and the read data is sampled at the following falling edge. The same-cycle race between a detection and a clear is produced by placing the clear strobe on that third rising edge. The level-mode vectors leave enough cycles for the synchroniser to settle before and after each acknowledge, and the expected detect values in the table account for that.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 12;
    localparam int SENSE_W = 6;

    // Sense codes held in the low field of each configuration word
    localparam logic [SENSE_W-1:0] SENSE_LVL_LO = 6'h01;
    localparam logic [SENSE_W-1:0] SENSE_LVL_HI = 6'h02;
    localparam logic [SENSE_W-1:0] SENSE_FALL   = 6'h04;
    localparam logic [SENSE_W-1:0] SENSE_RISE   = 6'h08;
    localparam logic [SENSE_W-1:0] SENSE_BOTH   = 6'h0C;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFS_PEND     = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_EN_SET   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_LEVEL    = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_CFG_BASE = 12'h180;

    typedef enum logic [2:0] {
        DET_OFF,
        DET_LVL_LO,
        DET_LVL_HI,
        DET_FALL,
        DET_RISE,
        DET_BOTH
    } det_mode_e;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_PEND,
        ACC_EN_CLR,
        ACC_EN_SET,
        ACC_STATUS,
        ACC_LEVEL,
        ACC_CFG
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [4:0] idx;
    } acc_dec_t;

    function automatic det_mode_e sense_to_mode(input logic [SENSE_W-1:0] code);
        det_mode_e m;
        case (code)
            SENSE_LVL_LO: m = DET_LVL_LO;
            SENSE_LVL_HI: m = DET_LVL_HI;
            SENSE_FALL:   m = DET_FALL;
            SENSE_RISE:   m = DET_RISE;
            SENSE_BOTH:   m = DET_BOTH;
            default:      m = DET_OFF;
        endcase
        return m;
    endfunction

    function automatic logic line_hit(input det_mode_e m, input logic lvl, input logic prev);
        logic h;
        case (m)
            DET_LVL_LO: h = ~lvl;
            DET_LVL_HI: h = lvl;
            DET_FALL:   h = prev & ~lvl;
            DET_RISE:   h = lvl & ~prev;
            DET_BOTH:   h = lvl ^ prev;
            default:    h = 1'b0;
        endcase
        return h;
    endfunction

    function automatic acc_dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int unsigned n_lines);
        acc_dec_t d;
        d.kind = ACC_NONE;
        d.idx  = a[6:2];
        case (a)
            OFS_PEND:   d.kind = ACC_PEND;
            OFS_EN_CLR: d.kind = ACC_EN_CLR;
            OFS_EN_SET: d.kind = ACC_EN_SET;
            OFS_STATUS: d.kind = ACC_STATUS;
            OFS_LEVEL:  d.kind = ACC_LEVEL;
            default: begin
                if (a[ADDR_W-1:7] == OFS_CFG_BASE[ADDR_W-1:7] && a[1:0] == 2'b00
                    && {27'd0, a[6:2]} < n_lines)
                    d.kind = ACC_CFG;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prev
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_line
            logic [STAGES-1:0] stg_q;
            logic              prev_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    stg_q  <= '0;
                    prev_q <= 1'b0;
                end else begin
                    stg_q  <= {stg_q[STAGES-2:0], raw[i]};
                    prev_q <= stg_q[STAGES-1];
                end
            end

            assign lvl[i]  = stg_q[STAGES-1];
            assign prev[i] = prev_q;
        end
    endgenerate

endmodule

// File: rtl/eic_detect.sv
module eic_detect
    import eic_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N-1:0]            lvl,
    input  logic [N-1:0]            prev,
    input  logic [N-1:0][SENSE_W-1:0] sense,
    input  logic [N-1:0]            clr_mask,
    output logic [N-1:0]            status_q
);

    logic [N-1:0] hit;

    generate
        for (genvar i = 0; i < N; i++) begin : g_hit
            assign hit[i] = line_hit(sense_to_mode(sense[i]), lvl[i], prev[i]);
        end
    endgenerate

    // New detections are ORed in after the clear, so they win a same-cycle race
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_mask) | hit;
    end

    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_mask & ~hit)) |=> ((status_q & $past(clr_mask & ~hit)) == '0));

    // R11
    hit_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ((status_q & $past(hit)) == $past(hit)));

    // R4
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (|status_q) |=> ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));

endmodule

// File: rtl/eic_regs.sv
module eic_regs
    import eic_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [BUS_W-1:0]          bus_wdata,
    input  logic                      bus_rd,
    output logic [BUS_W-1:0]          bus_rdata,
    input  logic [N-1:0]              status_q,
    input  logic [N-1:0]              pend,
    input  logic [N-1:0]              lvl,
    output logic [N-1:0]              en_q,
    output logic [N-1:0][SENSE_W-1:0] sense,
    output logic [N-1:0]              clr_mask
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    acc_dec_t        dec;
    logic [N-1:0]    wmask;
    logic [BUS_W-1:0] cfg_word [N];
    logic [BUS_W-1:0] rd_mux;

    assign dec      = decode_addr(bus_addr, N);
    assign wmask    = bus_wdata[N-1:0];
    assign clr_mask = (bus_wr && dec.kind == ACC_STATUS) ? wmask : '0;

    // Enable mask: separate set and clear addresses
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (bus_wr) begin
            case (dec.kind)
                ACC_EN_SET: en_q <= en_q | wmask;
                ACC_EN_CLR: en_q <= en_q & ~wmask;
                default:    ;
            endcase
        end
    end

    // Per-line configuration words
    generate
        for (genvar i = 0; i < N; i++) begin : g_cfg
            logic [BUS_W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (rst)
                    word_q <= '0;
                else if (bus_wr && dec.kind == ACC_CFG && dec.idx == 5'(i))
                    word_q <= bus_wdata;
            end
            assign cfg_word[i] = word_q;
            assign sense[i]    = word_q[SENSE_W-1:0];
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        case (dec.kind)
            ACC_PEND:               rd_mux[N-1:0] = pend;
            ACC_EN_CLR, ACC_EN_SET: rd_mux[N-1:0] = en_q;
            ACC_STATUS:             rd_mux[N-1:0] = status_q;
            ACC_LEVEL:              rd_mux[N-1:0] = lvl;
            ACC_CFG:                rd_mux = cfg_word[dec.idx[IDX_W-1:0]];
            default:                ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec.kind == ACC_EN_SET) |=>
            (en_q == ($past(en_q) | $past(wmask))));

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec.kind == ACC_EN_CLR) |=>
            (((en_q & $past(wmask)) == '0) && ((en_q & ~$past(wmask)) == ($past(en_q) & ~$past(wmask)))));

    // R3
    en_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (dec.kind == ACC_EN_SET || dec.kind == ACC_EN_CLR)) |=> $stable(en_q));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int N_LINES     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [BUS_W-1:0]     bus_wdata,
    input  logic                 bus_rd,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [N_LINES-1:0]   irq_line_in,
    output logic [N_LINES-1:0]   irq_out
);

    logic [N_LINES-1:0]              lvl;
    logic [N_LINES-1:0]              prev;
    logic [N_LINES-1:0][SENSE_W-1:0] sense;
    logic [N_LINES-1:0]              clr_mask;
    logic [N_LINES-1:0]              status_q;
    logic [N_LINES-1:0]              en_q;
    logic [N_LINES-1:0]              pend;

    eic_sync #(.N(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (irq_line_in),
        .lvl  (lvl),
        .prev (prev)
    );

    eic_detect #(.N(N_LINES)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl),
        .prev     (prev),
        .sense    (sense),
        .clr_mask (clr_mask),
        .status_q (status_q)
    );

    eic_regs #(.N(N_LINES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .status_q  (status_q),
        .pend      (pend),
        .lvl       (lvl),
        .en_q      (en_q),
        .sense     (sense),
        .clr_mask  (clr_mask)
    );

    assign pend    = status_q & en_q;
    assign irq_out = pend;

    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(en_q) == '0 && en_q == '0) |-> (irq_out == '0));

endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb_top;

    localparam int NL = 32;

    typedef struct packed {
        logic [4:0]  line;
        logic [31:0] code;
        logic        v0;
        logic        v1;
        logic        expd;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{5'd0,  32'h01, 1'b1, 1'b1, 1'b0},
        '{5'd1,  32'h01, 1'b1, 1'b0, 1'b1},
        '{5'd2,  32'h02, 1'b0, 1'b0, 1'b0},
        '{5'd3,  32'h02, 1'b0, 1'b1, 1'b1},
        '{5'd4,  32'h04, 1'b1, 1'b0, 1'b1},
        '{5'd5,  32'h04, 1'b0, 1'b1, 1'b0},
        '{5'd6,  32'h08, 1'b0, 1'b1, 1'b1},
        '{5'd8,  32'h08, 1'b1, 1'b0, 1'b0},
        '{5'd9,  32'h0C, 1'b0, 1'b1, 1'b1},
        '{5'd10, 32'h0C, 1'b1, 1'b0, 1'b1},
        '{5'd11, 32'h0C, 1'b1, 1'b1, 1'b0},
        '{5'd12, 32'h00, 1'b0, 1'b1, 1'b0},
        '{5'd13, 32'h03, 1'b1, 1'b0, 1'b0},
        '{5'd14, 32'h10, 1'b0, 1'b1, 1'b0},
        '{5'd30, 32'h48, 1'b0, 1'b1, 1'b1},
        '{5'd31, 32'h0B, 1'b0, 1'b1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] lines = '0;
    logic [NL-1:0] irq_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    ext_irq_ctrl #(.N_LINES(NL)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata),
        .irq_line_in (lines),
        .irq_out     (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp_v);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic string vec_req(input logic [31:0] code);
        if (code[31:6] != '0) return "R5";
        case (code[5:0])
            6'h01, 6'h02:        return "R6";
            6'h04, 6'h08, 6'h0C: return "R7";
            default:             return "R8";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;

        // R1: reset state
        tick(3);
        rst = 1'b0;
        tick(1);
        check("R1 irq_out", 32'(irq_out), 32'h0);
        bus_read(12'h004, rd); check("R1 enable", rd, 32'h0);
        bus_read(12'h100, rd); check("R1 status", rd, 32'h0);
        bus_read(12'h000, rd); check("R1 pending", rd, 32'h0);
        bus_read(12'h180, rd); check("R1 cfg0", rd, 32'h0);

        // R2: set enables
        bus_write(12'h008, 32'h0000_00F0);
        bus_write(12'h008, 32'h0000_0003);
        bus_read(12'h004, rd); check("R2 set", rd, 32'h0000_00F3);
        bus_read(12'h008, rd); check("R3 read via set addr", rd, 32'h0000_00F3);

        // R3: clear enables
        bus_write(12'h004, 32'h0000_0030);
        bus_read(12'h004, rd); check("R3 clear", rd, 32'h0000_00C3);
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_read(12'h004, rd); check("R3 clear all", rd, 32'h0);

        // R5: configuration words hold all bits
        bus_write(12'h194, 32'hDEAD_BE00);
        bus_read(12'h194, rd); check("R5 cfg5", rd, 32'hDEAD_BE00);
        bus_write(12'h1FC, 32'h1234_5640);
        bus_read(12'h1FC, rd); check("R5 cfg31", rd, 32'h1234_5640);
        bus_write(12'h194, 32'h0);
        bus_write(12'h1FC, 32'h0);

        // R9: level monitor
        lines = 32'hA5A5_0F0F;
        tick(2);
        bus_read(12'h104, rd); check("R9 monitor", rd, 32'hA5A5_0F0F);
        lines = '0;
        tick(3);

        // R12 and R7: latency of a rising edge on line 7
        bus_write(12'h19C, 32'h08);
        bus_write(12'h008, 32'h80);
        lines[7] = 1'b1;
        tick(1); check("R12 edge+1", 32'(irq_out[7]), 32'h0);
        tick(1); check("R12 edge+2", 32'(irq_out[7]), 32'h0);
        tick(1); check("R12 edge+3", 32'(irq_out[7]), 32'h1);
        bus_write(12'h100, 32'h80);
        check("R4 ack", 32'(irq_out[7]), 32'h0);

        // R11: clear strobe on the same edge as the detection
        lines[7] = 1'b0;
        tick(3);
        lines[7] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h100; bus_wdata = 32'h80;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R11 detect wins", 32'(irq_out[7]), 32'h1);
        bus_read(12'h100, rd); check("R11 status", rd, 32'h80);

        // R10: pending is status AND enable
        bus_read(12'h000, rd); check("R10 pending", rd, 32'h80);
        bus_write(12'h004, 32'h80);
        bus_read(12'h000, rd); check("R10 masked pending", rd, 32'h0);
        check("R10 masked irq", 32'(irq_out), 32'h0);
        bus_read(12'h100, rd); check("R10 status kept", rd, 32'h80);
        bus_write(12'h008, 32'h80);

        // R4: zero writes ignored, one writes clear
        bus_write(12'h100, 32'h0);
        bus_read(12'h100, rd); check("R4 write zero", rd, 32'h80);
        bus_write(12'h100, 32'h80);
        bus_read(12'h100, rd); check("R4 write one", rd, 32'h0);

        // R6: clear during an active level does not stick
        bus_write(12'h188, 32'h02);
        bus_write(12'h008, 32'h04);
        lines[2] = 1'b1;
        tick(4);
        bus_write(12'h100, 32'h04);
        tick(1);
        bus_read(12'h100, rd); check("R6 level reasserts", rd, 32'h04);
        lines[2] = 1'b0;
        tick(4);
        bus_write(12'h100, 32'h04);
        bus_read(12'h100, rd); check("R6 level gone", rd, 32'h0);

        bus_write(12'h188, 32'h0);
        bus_write(12'h19C, 32'h0);
        bus_write(12'h004, 32'hFFFF_FFFF);
        lines = '0;
        tick(4);
        bus_write(12'h100, 32'hFFFF_FFFF);

        // Table of sense-mode vectors (R5, R6, R7, R8)
        for (int v = 0; v < 16; v++) begin
            logic [11:0] cfg_a;
            logic [31:0] bitm;
            cfg_a = 12'h180 + {5'd0, VECS[v].line, 2'b00};
            bitm  = 32'h1 << VECS[v].line;
            bus_write(cfg_a, VECS[v].code);
            bus_write(12'h008, bitm);
            lines[VECS[v].line] = VECS[v].v0;
            tick(5);
            bus_write(12'h100, 32'hFFFF_FFFF);
            lines[VECS[v].line] = VECS[v].v1;
            tick(5);
            check($sformatf("%s vec%0d irq", vec_req(VECS[v].code), v),
                  32'(irq_out[VECS[v].line]), 32'(VECS[v].expd));
            bus_read(12'h100, rd);
            check($sformatf("%s vec%0d status", vec_req(VECS[v].code), v),
                  rd, VECS[v].expd ? bitm : 32'h0);
            bus_write(cfg_a, 32'h0);
            bus_write(12'h004, bitm);
            lines[VECS[v].line] = 1'b0;
            tick(5);
            bus_write(12'h100, 32'hFFFF_FFFF);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule